// File: doc/BRIEF.md
# Region Output Resolver

This block chooses the level of a console's 50/60Hz video select line and of a separate region flag bit that software can read. It combines three things: the user's preferred mode (fixed 60Hz, fixed 50Hz or automatic), the region type reported for the cartridge's key device, and a strap that enables a start-up override window.

While the window is open after a console reset, the video line shows the region the key reports. Many titles sample the console region only at boot, so they see a console that matches the cartridge. When the window closes, the line falls back to the user's choice. The window is measured in slow ticks from an external timebase, for example one tick every 586 ms.

When no key is found, or the key is later judged invalid, the block behaves as if the window had already closed. The region flag then simply mirrors the video line. The mode, key and strap inputs are expected to be already synchronised to the block clock.

Top module: `region_resolver`

## Requirements
- R1: A synchronous active-high reset drives `vid_50hz` and `d4_flag` to 0 on the following clock, forgets any key and restarts the window tick count from zero.
- R2: `user_mode` encoding: 2'b00 selects 60Hz (`vid_50hz`=0), 2'b01 selects 50Hz (`vid_50hz`=1), and 2'b10 and 2'b11 both select Auto. Outside the window, or with no key, a fixed mode drives the line to its own rate.
- R3: With `timeout_en`=1 and a key reported (a `key_valid` pulse, where `key_pal`=1 means a 50Hz-type key and 0 means a 60Hz-type key), `vid_50hz` follows the key type until `TIMEOUT_TICKS` (default 16) `tick` pulses have been counted since reset. After that it follows the user mode.
- R4: In Auto mode `vid_50hz` is 1 for a 50Hz-type key and 0 for a 60Hz-type key or for no key, both inside and after the window.
- R5: With `timeout_en`=0 the window counts as already closed, so the user mode drives `vid_50hz` even while a key is known.
- R6: A `key_invalid` pulse latches until reset. It discards the key (the detected region becomes 60Hz), closes the window, and later `key_valid` pulses are ignored.
- R7: While a valid key is known, `d4_flag` equals `key_pal`, whatever the mode or window state.
- R8: With no valid key (none reported, or invalidated), `d4_flag` equals `vid_50hz`, so it is 0 in Auto.
- R9: Once the window has closed, a change of `user_mode` reaches `vid_50hz` on the next rising clock edge, not before.
- R10: The tick count saturates at `TIMEOUT_TICKS`. Further ticks do not change the outputs, and only a reset reopens the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high console reset |
| user_mode | input | 2 | User mode: 00 60Hz, 01 50Hz, 1x Auto |
| key_valid | input | 1 | One-cycle strobe: key type on `key_pal` is valid |
| key_pal | input | 1 | Key type: 1 = 50Hz-type, 0 = 60Hz-type |
| key_invalid | input | 1 | Pulse: key failed its check (sticky until reset) |
| timeout_en | input | 1 | Strap: 1 enables the start-up override window |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| vid_50hz | output | 1 | Video rate select: 1 = 50Hz, 0 = 60Hz |
| d4_flag | output | 1 | Region flag bit for software |

## Verification
The bench drives each mode against each key type across the window boundary. It checks the last tick before expiry and the tick that closes the window, so a design with an off-by-one count would flip the line a tick early or late. It also checks that a key turned invalid forces the user setting at once and drags `d4_flag` along, and that a late `key_valid` after invalidation is ignored; a design without the sticky flag would bring the key back. It samples the one-cycle mode-to-output latency on both sides of the edge. Finally it resets after expiry and checks that the window reopens, so a design that never restarts the count would show the user setting straight away.

// File: rtl/region_pkg.sv
package region_pkg;

    typedef enum logic [1:0] {
        MODE_60       = 2'b00,
        MODE_50       = 2'b01,
        MODE_AUTO     = 2'b10,
        MODE_AUTO_ALT = 2'b11
    } user_mode_e;

    typedef struct packed {
        logic known;   // a valid key type has been reported
        logic pal;     // reported type: 1 = 50Hz-type
    } key_state_t;

    typedef struct packed {
        logic vid_50hz;
        logic d4;
    } region_out_t;

    function automatic logic mode_is_auto(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic fixed_mode_is_50(input logic [1:0] m);
        return (m == MODE_50);
    endfunction

endpackage

// File: rtl/key_tracker.sv
module key_tracker
    import region_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_valid,
    input  logic       key_pal,
    input  logic       key_invalid,
    output key_state_t key_st,
    output logic       invalid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_st    <= '0;
            invalid_q <= 1'b0;
        end else if (key_invalid) begin
            key_st    <= '0;
            invalid_q <= 1'b1;
        end else if (key_valid && !invalid_q) begin
            key_st.known <= 1'b1;
            key_st.pal   <= key_pal;
        end
    end

endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int TIMEOUT_TICKS = 16,
    localparam int CNT_W = (TIMEOUT_TICKS < 1) ? 1 : $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             timeout_en,
    input  logic             invalid_q,
    output logic [CNT_W-1:0] tick_count,
    output logic             window_closed
);

    logic count_done;

    generate
        if (TIMEOUT_TICKS < 1) begin : g_no_window
            assign tick_count = '0;
            assign count_done = 1'b1;
        end else begin : g_window
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (tick && (cnt_q != LIMIT))
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_count = cnt_q;
            assign count_done = (cnt_q == LIMIT);
        end
    endgenerate

    assign window_closed = count_done | ~timeout_en | invalid_q;

endmodule

// File: rtl/region_select.sv
module region_select
    import region_pkg::*;
(
    input  logic [1:0]  user_mode,
    input  key_state_t  key_st,
    input  logic        window_closed,
    output region_out_t nxt
);

    logic det_50;
    logic user_50;

    always_comb begin
        det_50  = key_st.known & key_st.pal;
        user_50 = mode_is_auto(user_mode) ? det_50 : fixed_mode_is_50(user_mode);

        if (key_st.known && !window_closed)
            nxt.vid_50hz = key_st.pal;
        else
            nxt.vid_50hz = user_50;

        nxt.d4 = key_st.known ? key_st.pal : nxt.vid_50hz;
    end

endmodule

// File: rtl/region_resolver.sv
module region_resolver
    import region_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] user_mode,
    input  logic       key_valid,
    input  logic       key_pal,
    input  logic       key_invalid,
    input  logic       timeout_en,
    input  logic       tick,
    output logic       vid_50hz,
    output logic       d4_flag
);

    localparam int CNT_W = (TIMEOUT_TICKS < 1) ? 1 : $clog2(TIMEOUT_TICKS + 1);

    key_state_t       key_st;
    logic             invalid_q;
    logic [CNT_W-1:0] tick_count;
    logic             window_closed;
    region_out_t      nxt;
    region_out_t      out_q;
    logic             key_known_w;
    logic             key_pal_w;

    key_tracker u_key (
        .clk         (clk),
        .rst         (rst),
        .key_valid   (key_valid),
        .key_pal     (key_pal),
        .key_invalid (key_invalid),
        .key_st      (key_st),
        .invalid_q   (invalid_q)
    );

    window_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_win (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .timeout_en    (timeout_en),
        .invalid_q     (invalid_q),
        .tick_count    (tick_count),
        .window_closed (window_closed)
    );

    region_select u_sel (
        .user_mode     (user_mode),
        .key_st        (key_st),
        .window_closed (window_closed),
        .nxt           (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= nxt;
    end

    assign vid_50hz    = out_q.vid_50hz;
    assign d4_flag     = out_q.d4;
    assign key_known_w = key_st.known;
    assign key_pal_w   = key_st.pal;

endmodule

// File: rtl/region_resolver_chk.sv
module region_resolver_chk #(
    parameter int TIMEOUT_TICKS = 16,
    localparam int CNT_W = (TIMEOUT_TICKS < 1) ? 1 : $clog2(TIMEOUT_TICKS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       user_mode,
    input logic             timeout_en,
    input logic             vid_50hz,
    input logic             d4_flag,
    input logic             key_known,
    input logic             key_pal_q,
    input logic             invalid_q,
    input logic [CNT_W-1:0] tick_count
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!vid_50hz && !d4_flag));

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_count <= CNT_W'(TIMEOUT_TICKS)));

    // R6
    invalid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        invalid_q |=> invalid_q);

    // R6
    invalid_drops_key_chk: assert property (@(posedge clk) disable iff (rst)
        invalid_q |-> !key_known);

    // R7
    d4_key_chk: assert property (@(posedge clk) disable iff (rst)
        key_known |=> (d4_flag == $past(key_pal_q)));

    // R8
    d4_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        !key_known |=> (d4_flag == vid_50hz));

    // R5
    strap_50_chk: assert property (@(posedge clk) disable iff (rst)
        (!timeout_en && user_mode == 2'b01) |=> vid_50hz);

    // R5
    strap_60_chk: assert property (@(posedge clk) disable iff (rst)
        (!timeout_en && user_mode == 2'b00) |=> !vid_50hz);

endmodule

bind region_resolver region_resolver_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .user_mode  (user_mode),
    .timeout_en (timeout_en),
    .vid_50hz   (vid_50hz),
    .d4_flag    (d4_flag),
    .key_known  (key_known_w),
    .key_pal_q  (key_pal_w),
    .invalid_q  (invalid_q),
    .tick_count (tick_count)
);

// File: tb/sim_region_resolver.sv
`timescale 1ns/1ps
module sim_region_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int NTICKS     = 16;
    localparam logic [1:0] M60   = 2'b00;
    localparam logic [1:0] M50   = 2'b01;
    localparam logic [1:0] MAUTO = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] user_mode = 2'b00;
    logic       key_valid = 1'b0;
    logic       key_pal = 1'b0;
    logic       key_invalid = 1'b0;
    logic       timeout_en = 1'b1;
    logic       tick = 1'b0;
    logic       vid_50hz;
    logic       d4_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_resolver #(.TIMEOUT_TICKS(NTICKS)) u0 (
        .clk(clk), .rst(rst), .user_mode(user_mode), .key_valid(key_valid),
        .key_pal(key_pal), .key_invalid(key_invalid), .timeout_en(timeout_en),
        .tick(tick), .vid_50hz(vid_50hz), .d4_flag(d4_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic strap);
        @(negedge clk);
        rst = 1'b1; user_mode = m; timeout_en = strap;
        key_valid = 1'b0; key_invalid = 1'b0; tick = 1'b0;
        wait_cyc(2);
        rst = 1'b0;
    endtask

    task automatic send_key(input logic pal);
        key_pal = pal; key_valid = 1'b1;
        @(negedge clk);
        key_valid = 1'b0;
        wait_cyc(2);
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
        wait_cyc(2);
    endtask

    task automatic t_reset();
        do_reset(M50, 1'b1);
        chk("R1 reset vid", vid_50hz, 1'b0);
        chk("R1 reset d4", d4_flag, 1'b0);
    endtask

    task automatic t_mode60_pal();
        do_reset(M60, 1'b1);
        send_key(1'b1);
        chk("R3 window shows 50Hz key", vid_50hz, 1'b1);
        chk("R7 d4 pal key", d4_flag, 1'b1);
        send_ticks(NTICKS - 1);
        chk("R3 still in window at last-but-one tick", vid_50hz, 1'b1);
        send_ticks(1);
        chk("R3 after window mode 60", vid_50hz, 1'b0);
        chk("R7 d4 pal key after window", d4_flag, 1'b1);
        send_ticks(5);
        chk("R10 extra ticks no effect", vid_50hz, 1'b0);
    endtask

    task automatic t_mode50_ntsc();
        do_reset(M50, 1'b1);
        send_key(1'b0);
        chk("R3 window shows 60Hz key", vid_50hz, 1'b0);
        chk("R7 d4 ntsc key", d4_flag, 1'b0);
        send_ticks(NTICKS);
        chk("R3 after window mode 50", vid_50hz, 1'b1);
        chk("R7 d4 ntsc after window", d4_flag, 1'b0);
    endtask

    task automatic t_auto();
        do_reset(MAUTO, 1'b1);
        send_key(1'b1);
        chk("R4 auto pal in window", vid_50hz, 1'b1);
        send_ticks(NTICKS);
        chk("R4 auto pal after window", vid_50hz, 1'b1);
        do_reset(2'b11, 1'b1);
        send_key(1'b0);
        send_ticks(NTICKS);
        chk("R4 auto(11) ntsc after window", vid_50hz, 1'b0);
        do_reset(MAUTO, 1'b1);
        wait_cyc(2);
        chk("R4 auto no key", vid_50hz, 1'b0);
        chk("R8 d4 auto no key", d4_flag, 1'b0);
    endtask

    task automatic t_nokey();
        do_reset(M50, 1'b1);
        wait_cyc(2);
        chk("R2 no key mode 50", vid_50hz, 1'b1);
        chk("R8 d4 follows output", d4_flag, 1'b1);
    endtask

    task automatic t_strap_low();
        do_reset(M60, 1'b0);
        send_key(1'b1);
        chk("R5 strap low user 60", vid_50hz, 1'b0);
        chk("R7 d4 pal strap low", d4_flag, 1'b1);
    endtask

    task automatic t_invalid();
        do_reset(M50, 1'b1);
        send_key(1'b0);
        chk("R6 pre-invalid window", vid_50hz, 1'b0);
        key_invalid = 1'b1;
        @(negedge clk);
        key_invalid = 1'b0;
        wait_cyc(2);
        chk("R6 invalid forces user 50", vid_50hz, 1'b1);
        chk("R6 invalid d4 follows output", d4_flag, 1'b1);
        send_key(1'b0);
        chk("R6 key after invalid ignored", d4_flag, 1'b1);
        user_mode = MAUTO;
        wait_cyc(2);
        chk("R6 invalid auto -> 60", vid_50hz, 1'b0);
        chk("R8 invalid auto d4", d4_flag, 1'b0);
    endtask

    task automatic t_latency();
        do_reset(M60, 1'b1);
        send_ticks(NTICKS);
        chk("R2 no key mode 60", vid_50hz, 1'b0);
        user_mode = M50;
        #1;
        chk("R9 no change before edge", vid_50hz, 1'b0);
        @(negedge clk);
        chk("R9 change after one edge", vid_50hz, 1'b1);
    endtask

    task automatic t_restart();
        do_reset(M60, 1'b1);
        send_key(1'b1);
        send_ticks(NTICKS);
        chk("R10 window closed", vid_50hz, 1'b0);
        do_reset(M60, 1'b1);
        send_key(1'b1);
        chk("R1 reset reopens window", vid_50hz, 1'b1);
    endtask

    initial begin
        t_reset();
        t_mode60_pal();
        t_mode50_ntsc();
        t_auto();
        t_nokey();
        t_strap_low();
        t_invalid();
        t_latency();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule